// File: doc/BRIEF.md
# Automatic Xon/Xoff Flow Controller

This block watches the fill level of a UART receive FIFO and tells the remote transmitter to pause or resume by placing software flow-control characters into the local transmit stream. When the fill level reaches a programmable trigger, it sends a stop sequence. When the level drops back under the trigger, it sends a resume sequence. A register bit remembers whether the remote side has been told to stop, so each crossing produces exactly one sequence.

Each sequence is either one character or a pair of characters, chosen by a mode input. In pair mode, a single stray data byte cannot be read as a flow-control command. The four character values are held in writable 8-bit registers. The block sits in front of the serializer as a one-entry registered stage with a valid/ready handshake. Control characters take priority over data from the transmit FIFO, and a data byte never goes out between the two characters of a pair.

Top module: `xonxoff_flowctl`

## Requirements
- R1: After reset, `tx_valid` is 0, `data_ready` is 1, the remote side is treated as running, nothing is pending, the resume registers hold 0x11 and the stop registers hold 0x13.
- R2: While enabled, when `rx_level` is at or above the effective trigger, one stop sequence is transmitted.
- R3: After a stop sequence, when `rx_level` falls below the effective trigger, one resume sequence is transmitted.
- R4: No further sequence is sent while the level stays on the same side of the trigger.
- R5: With `two_char_mode` = 0, a sequence is the single first character: stop1 or resume1.
- R6: With `two_char_mode` = 1, a sequence is the first character followed by the second character (stop1 then stop2, or resume1 then resume2). The two characters are accepted in consecutive cycles while `tx_ready` stays high.
- R7: While a sequence is pending or under way, `data_ready` is 0. Pending control characters go out before any data byte that has not yet been accepted.
- R8: With no event pending, accepted data bytes appear on `tx_byte` unchanged and in order, each presented in the cycle after it is accepted.
- R9: If the level crosses back before a pending sequence has started, the event is dropped and nothing is sent. If a sequence has already started, it finishes and is then followed by the opposite sequence.
- R10: Clearing `fc_enable` while the remote side is stopped sends one resume sequence. While disabled, level changes send nothing.
- R11: A trigger value of 0 acts as 1, and any value above 64 acts as 64.
- R12: A write with `cfg_wr_sel` = 0, 1, 2 or 3 sets resume1, resume2, stop1 or stop2 respectively to `cfg_wr_data`.
- R13: While `tx_valid` is 1 and `tx_ready` is 0, `tx_valid` and `tx_byte` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fc_enable | input | 1 | Enables automatic flow control |
| two_char_mode | input | 1 | 1: two-character sequences, 0: one character |
| rx_trigger | input | LEVEL_W | Receive trigger level (1..64 after clamping) |
| rx_level | input | LEVEL_W | Current receive FIFO fill level |
| cfg_wr_en | input | 1 | Character register write strobe |
| cfg_wr_sel | input | 2 | Register select: 0 resume1, 1 resume2, 2 stop1, 3 stop2 |
| cfg_wr_data | input | 8 | Character value to write |
| data_valid | input | 1 | Transmit FIFO has a data byte |
| data_byte | input | 8 | Data byte from transmit FIFO |
| data_ready | output | 1 | Data byte accepted this cycle when valid |
| tx_valid | output | 1 | Byte offered to the serializer |
| tx_byte | output | 8 | Byte offered to the serializer |
| tx_ready | input | 1 | Serializer takes the byte |

## Verification
The bench builds the block with its default parameters: a 7-bit level and trigger, a maximum trigger of 64, and 8-bit characters. These values make both ends of the trigger range reachable, so a trigger of 64 with levels 63 and 64 is tested, along with the clamping of 0 and 100. Holding `tx_ready` low lets the bench keep the output stage full while the level crosses back and forth. This separates a sequence that is cancelled from one that is already under way, and it shows control characters overtaking a waiting data byte.

// File: rtl/xfc_pkg.sv
package xfc_pkg;
  localparam int CHAR_W = 8;

  typedef enum logic [1:0] {
    SEL_RESUME1 = 2'd0,
    SEL_RESUME2 = 2'd1,
    SEL_STOP1   = 2'd2,
    SEL_STOP2   = 2'd3
  } char_sel_e;

  typedef enum logic {
    ARB_FREE = 1'b0,
    ARB_TAIL = 1'b1
  } arb_state_e;

  typedef struct packed {
    logic [CHAR_W-1:0] resume1;
    logic [CHAR_W-1:0] resume2;
    logic [CHAR_W-1:0] stop1;
    logic [CHAR_W-1:0] stop2;
  } ctrl_chars_t;
endpackage

// File: rtl/xfc_char_regs.sv
module xfc_char_regs
  import xfc_pkg::*;
#(
  parameter logic [CHAR_W-1:0] RESUME_RST = 8'h11,
  parameter logic [CHAR_W-1:0] STOP_RST   = 8'h13
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [1:0]        wr_sel,
  input  logic [CHAR_W-1:0] wr_data,
  output ctrl_chars_t       chars
);
  localparam int NUM_REGS = 4;

  logic [CHAR_W-1:0] regs_q [NUM_REGS];

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    localparam logic [CHAR_W-1:0] RST_VAL = (g < 2) ? RESUME_RST : STOP_RST;
    always_ff @(posedge clk) begin
      if (rst) begin
        regs_q[g] <= RST_VAL;
      end else if (wr_en && (wr_sel == 2'(g))) begin
        regs_q[g] <= wr_data;
      end
    end
  end

  always_comb begin
    chars.resume1 = regs_q[SEL_RESUME1];
    chars.resume2 = regs_q[SEL_RESUME2];
    chars.stop1   = regs_q[SEL_STOP1];
    chars.stop2   = regs_q[SEL_STOP2];
  end
endmodule

// File: rtl/xfc_event_tracker.sv
module xfc_event_tracker #(
  parameter int LEVEL_W  = 7,
  parameter int MAX_TRIG = 64
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               enable,
  input  logic [LEVEL_W-1:0] trigger,
  input  logic [LEVEL_W-1:0] level,
  input  logic               commit,
  output logic               pending,
  output logic               pend_is_stop,
  output logic               halted
);
  localparam logic [LEVEL_W-1:0] TRIG_MIN = LEVEL_W'(1);
  localparam logic [LEVEL_W-1:0] TRIG_MAX = LEVEL_W'(MAX_TRIG);

  logic [LEVEL_W-1:0] trig_eff;
  logic               above_q;
  logic               halted_q;

  always_comb begin
    if (trigger < TRIG_MIN) begin
      trig_eff = TRIG_MIN;
    end else if (trigger > TRIG_MAX) begin
      trig_eff = TRIG_MAX;
    end else begin
      trig_eff = trigger;
    end
  end

  // Desired remote state, registered once to cut the compare path.
  always_ff @(posedge clk) begin
    if (rst) begin
      above_q <= 1'b0;
    end else begin
      above_q <= enable && (level >= trig_eff);
    end
  end

  // State last announced to the remote side; it changes when a sequence starts.
  always_ff @(posedge clk) begin
    if (rst) begin
      halted_q <= 1'b0;
    end else if (commit) begin
      halted_q <= above_q;
    end
  end

  assign pending      = above_q != halted_q;
  assign pend_is_stop = above_q;
  assign halted       = halted_q;
endmodule

// File: rtl/xfc_tx_arbiter.sv
module xfc_tx_arbiter
  import xfc_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              pending,
  input  logic              pend_is_stop,
  input  logic              two_char,
  input  ctrl_chars_t       chars,
  input  logic              data_valid,
  input  logic [CHAR_W-1:0] data_byte,
  output logic              data_ready,
  output logic              commit,
  output logic              tail_busy,
  output logic              tx_valid,
  input  logic              tx_ready,
  output logic [CHAR_W-1:0] tx_byte
);
  arb_state_e        st_q;
  logic              out_valid_q;
  logic [CHAR_W-1:0] out_byte_q;
  logic [CHAR_W-1:0] tail_q;
  logic              load_en;
  logic              free;
  logic [CHAR_W-1:0] first_char;
  logic [CHAR_W-1:0] second_char;

  always_comb begin
    load_en     = !out_valid_q || tx_ready;
    free        = st_q == ARB_FREE;
    commit      = load_en && free && pending;
    data_ready  = load_en && free && !pending;
    first_char  = pend_is_stop ? chars.stop1 : chars.resume1;
    second_char = pend_is_stop ? chars.stop2 : chars.resume2;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q        <= ARB_FREE;
      out_valid_q <= 1'b0;
      out_byte_q  <= '0;
      tail_q      <= '0;
    end else if (load_en) begin
      if (st_q == ARB_TAIL) begin
        out_valid_q <= 1'b1;
        out_byte_q  <= tail_q;
        st_q        <= ARB_FREE;
      end else if (pending) begin
        out_valid_q <= 1'b1;
        out_byte_q  <= first_char;
        tail_q      <= second_char;
        st_q        <= two_char ? ARB_TAIL : ARB_FREE;
      end else if (data_valid) begin
        out_valid_q <= 1'b1;
        out_byte_q  <= data_byte;
      end else begin
        out_valid_q <= 1'b0;
      end
    end
  end

  assign tail_busy = st_q == ARB_TAIL;
  assign tx_valid  = out_valid_q;
  assign tx_byte   = out_byte_q;
endmodule

// File: rtl/xonxoff_flowctl.sv
module xonxoff_flowctl
  import xfc_pkg::*;
#(
  parameter int               LEVEL_W    = 7,
  parameter int               MAX_TRIG   = 64,
  parameter logic [CHAR_W-1:0] RESUME_RST = 8'h11,
  parameter logic [CHAR_W-1:0] STOP_RST   = 8'h13
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               fc_enable,
  input  logic               two_char_mode,
  input  logic [LEVEL_W-1:0] rx_trigger,
  input  logic [LEVEL_W-1:0] rx_level,
  input  logic               cfg_wr_en,
  input  logic [1:0]         cfg_wr_sel,
  input  logic [CHAR_W-1:0]  cfg_wr_data,
  input  logic               data_valid,
  input  logic [CHAR_W-1:0]  data_byte,
  output logic               data_ready,
  output logic               tx_valid,
  output logic [CHAR_W-1:0]  tx_byte,
  input  logic               tx_ready
);
  ctrl_chars_t chars;
  logic        pending;
  logic        pend_is_stop;
  logic        halted;
  logic        commit;
  logic        tail_busy;

  xfc_char_regs #(
    .RESUME_RST(RESUME_RST),
    .STOP_RST  (STOP_RST)
  ) u_regs (
    .clk    (clk),
    .rst    (rst),
    .wr_en  (cfg_wr_en),
    .wr_sel (cfg_wr_sel),
    .wr_data(cfg_wr_data),
    .chars  (chars)
  );

  xfc_event_tracker #(
    .LEVEL_W (LEVEL_W),
    .MAX_TRIG(MAX_TRIG)
  ) u_track (
    .clk         (clk),
    .rst         (rst),
    .enable      (fc_enable),
    .trigger     (rx_trigger),
    .level       (rx_level),
    .commit      (commit),
    .pending     (pending),
    .pend_is_stop(pend_is_stop),
    .halted      (halted)
  );

  xfc_tx_arbiter u_arb (
    .clk         (clk),
    .rst         (rst),
    .pending     (pending),
    .pend_is_stop(pend_is_stop),
    .two_char    (two_char_mode),
    .chars       (chars),
    .data_valid  (data_valid),
    .data_byte   (data_byte),
    .data_ready  (data_ready),
    .commit      (commit),
    .tail_busy   (tail_busy),
    .tx_valid    (tx_valid),
    .tx_ready    (tx_ready),
    .tx_byte     (tx_byte)
  );
endmodule

// File: rtl/xonxoff_flowctl_chk.sv
module xonxoff_flowctl_chk (
  input logic       clk,
  input logic       rst,
  input logic       pending,
  input logic       halted,
  input logic       tail_busy,
  input logic       data_valid,
  input logic [7:0] data_byte,
  input logic       data_ready,
  input logic       tx_valid,
  input logic [7:0] tx_byte,
  input logic       tx_ready
);
  AST_HOLD_WHILE_STALLED: assert property (@(posedge clk) disable iff (rst)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_byte))); // R13

  AST_NO_DATA_WHILE_PENDING: assert property (@(posedge clk) disable iff (rst)
    (pending || tail_busy) |-> !data_ready); // R7

  AST_DATA_PASSES: assert property (@(posedge clk) disable iff (rst)
    (data_valid && data_ready) |=> (tx_valid && tx_byte == $past(data_byte))); // R8

  AST_TAIL_BACK_TO_BACK: assert property (@(posedge clk) disable iff (rst)
    (tail_busy && tx_valid && tx_ready) |=> tx_valid); // R6

  AST_HALT_ONLY_ON_SEND: assert property (@(posedge clk) disable iff (rst)
    (halted != $past(halted)) |-> tx_valid); // R4
endmodule

bind xonxoff_flowctl xonxoff_flowctl_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .pending   (pending),
  .halted    (halted),
  .tail_busy (tail_busy),
  .data_valid(data_valid),
  .data_byte (data_byte),
  .data_ready(data_ready),
  .tx_valid  (tx_valid),
  .tx_byte   (tx_byte),
  .tx_ready  (tx_ready)
);

// File: tb/xonxoff_flowctl_tb.sv
module xonxoff_flowctl_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       fc_enable = 1'b0;
  logic       two_char_mode = 1'b0;
  logic [6:0] rx_trigger = 7'd8;
  logic [6:0] rx_level = 7'd0;
  logic       cfg_wr_en = 1'b0;
  logic [1:0] cfg_wr_sel = 2'd0;
  logic [7:0] cfg_wr_data = 8'd0;
  logic       data_valid;
  logic [7:0] data_byte;
  logic       data_ready;
  logic       tx_valid;
  logic [7:0] tx_byte;
  logic       tx_ready = 1'b1;

  int vectors = 0;
  int fails = 0;
  int cyc = 0;

  logic [7:0] src [16];
  int src_cnt = 0;
  int src_idx = 0;
  logic [7:0] log_b [64];
  int log_c [64];
  int log_n = 0;
  int base = 0;

  assign data_valid = src_idx < src_cnt;
  assign data_byte  = src[src_idx];

  always #10 clk = ~clk;

  xonxoff_flowctl u_dut (
    .clk(clk), .rst(rst), .fc_enable(fc_enable), .two_char_mode(two_char_mode),
    .rx_trigger(rx_trigger), .rx_level(rx_level), .cfg_wr_en(cfg_wr_en),
    .cfg_wr_sel(cfg_wr_sel), .cfg_wr_data(cfg_wr_data), .data_valid(data_valid),
    .data_byte(data_byte), .data_ready(data_ready), .tx_valid(tx_valid),
    .tx_byte(tx_byte), .tx_ready(tx_ready)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (!rst && data_valid && data_ready) src_idx <= src_idx + 1;
    if (!rst && tx_valid && tx_ready) begin
      log_b[log_n] <= tx_byte;
      log_c[log_n] <= cyc;
      log_n <= log_n + 1;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic push(input logic [7:0] b);
    src[src_cnt] = b;
    src_cnt++;
  endtask

  task automatic mark();
    base = log_n;
  endtask

  // Checks the bytes sent since mark(); n up to 4.
  task automatic chk_seq(input string req, input int n, input logic [7:0] e0,
                         input logic [7:0] e1, input logic [7:0] e2, input logic [7:0] e3);
    logic [7:0] e [4];
    e[0] = e0; e[1] = e1; e[2] = e2; e[3] = e3;
    chk(log_n - base == n, {req, " count"}, log_n - base, n);
    for (int i = 0; i < n && i < log_n - base; i++) begin
      chk(log_b[base + i] == e[i], req, log_b[base + i], e[i]);
    end
    base = log_n;
  endtask

  task automatic chk_adjacent(input string req, input int idx);
    chk(log_c[idx + 1] == log_c[idx] + 1, req, log_c[idx + 1] - log_c[idx], 1);
  endtask

  task automatic write_char(input logic [1:0] sel, input logic [7:0] val);
    cfg_wr_en = 1'b1; cfg_wr_sel = sel; cfg_wr_data = val;
    wait_cyc(1);
    cfg_wr_en = 1'b0;
  endtask

  task automatic t_reset();
    chk(tx_valid == 1'b0, "R1 tx_valid", tx_valid, 0);
    chk(data_ready == 1'b1, "R1 data_ready", data_ready, 1);
  endtask

  task automatic t_single();
    fc_enable = 1'b1; two_char_mode = 1'b0; rx_trigger = 7'd8;
    mark();
    rx_level = 7'd8; wait_cyc(8);
    chk_seq("R2 R5 R1 default stop", 1, 8'h13, 0, 0, 0);
    rx_level = 7'd12; wait_cyc(20);
    chk_seq("R4 no resend", 0, 0, 0, 0, 0);
    rx_level = 7'd3; wait_cyc(8);
    chk_seq("R3 R1 default resume", 1, 8'h11, 0, 0, 0);
    wait_cyc(10);
    chk_seq("R4 no second resume", 0, 0, 0, 0, 0);
  endtask

  task automatic t_regs_pair();
    write_char(2'd0, 8'hA1); write_char(2'd1, 8'hA2);
    write_char(2'd2, 8'hB1); write_char(2'd3, 8'hB2);
    two_char_mode = 1'b1; rx_trigger = 7'd64;
    mark();
    rx_level = 7'd64; wait_cyc(10);
    chk_adjacent("R6 stop pair adjacent", base);
    chk_seq("R6 R12 stop pair", 2, 8'hB1, 8'hB2, 0, 0);
    rx_level = 7'd63; wait_cyc(10);
    chk_adjacent("R6 resume pair adjacent", base);
    chk_seq("R6 R12 resume pair", 2, 8'hA1, 8'hA2, 0, 0);
  endtask

  task automatic t_priority();
    tx_ready = 1'b0; mark();
    push(8'h55); wait_cyc(3);
    rx_level = 7'd64; wait_cyc(5);
    push(8'h66); wait_cyc(2);
    chk(data_ready == 1'b0, "R7 data held off", data_ready, 0);
    tx_ready = 1'b1; wait_cyc(10);
    chk_seq("R7 control before data", 4, 8'h55, 8'hB1, 8'hB2, 8'h66);
    rx_level = 7'd0; wait_cyc(10);
    chk_seq("R3 resume after priority", 2, 8'hA1, 8'hA2, 0, 0);
  endtask

  task automatic t_passthru();
    mark();
    push(8'h01); push(8'h02); push(8'h03);
    wait_cyc(10);
    chk_seq("R8 data passthrough", 3, 8'h01, 8'h02, 8'h03, 0);
  endtask

  task automatic t_cancel();
    tx_ready = 1'b0; mark();
    push(8'h77); wait_cyc(3);
    rx_level = 7'd64; wait_cyc(4);
    rx_level = 7'd0; wait_cyc(4);
    tx_ready = 1'b1; wait_cyc(10);
    chk_seq("R9 cancelled before start", 1, 8'h77, 0, 0, 0);
    tx_ready = 1'b0;
    rx_level = 7'd64; wait_cyc(4);
    rx_level = 7'd0; wait_cyc(4);
    tx_ready = 1'b1; wait_cyc(12);
    chk_seq("R9 started then opposite", 4, 8'hB1, 8'hB2, 8'hA1, 8'hA2);
  endtask

  task automatic t_disable();
    two_char_mode = 1'b0; mark();
    rx_level = 7'd64; wait_cyc(8);
    chk_seq("R10 stop before disable", 1, 8'hB1, 0, 0, 0);
    fc_enable = 1'b0; wait_cyc(8);
    chk_seq("R10 resume on disable", 1, 8'hA1, 0, 0, 0);
    rx_level = 7'd0; wait_cyc(4);
    rx_level = 7'd64; wait_cyc(8);
    chk_seq("R10 disabled ignores level", 0, 0, 0, 0, 0);
    rx_level = 7'd0; fc_enable = 1'b1; wait_cyc(8);
    chk_seq("R10 re-enable below trigger", 0, 0, 0, 0, 0);
  endtask

  task automatic t_clamp();
    mark();
    rx_trigger = 7'd0; rx_level = 7'd1; wait_cyc(8);
    chk_seq("R11 zero trigger acts as 1", 1, 8'hB1, 0, 0, 0);
    rx_level = 7'd0; wait_cyc(8);
    chk_seq("R11 resume below 1", 1, 8'hA1, 0, 0, 0);
    rx_trigger = 7'd100; rx_level = 7'd64; wait_cyc(8);
    chk_seq("R11 large trigger acts as 64", 1, 8'hB1, 0, 0, 0);
    rx_level = 7'd63; wait_cyc(8);
    chk_seq("R11 resume below 64", 1, 8'hA1, 0, 0, 0);
  endtask

  task automatic t_hold();
    tx_ready = 1'b0; mark();
    push(8'h99); wait_cyc(3);
    chk(tx_valid && tx_byte == 8'h99, "R13 loaded", tx_byte, 8'h99);
    wait_cyc(5);
    chk(tx_valid && tx_byte == 8'h99, "R13 held", tx_byte, 8'h99);
    tx_ready = 1'b1; wait_cyc(4);
    chk_seq("R13 released once", 1, 8'h99, 0, 0, 0);
  endtask

  initial begin
    wait_cyc(3);
    rst = 1'b0;
    wait_cyc(1);
    t_reset();
    t_single();
    t_regs_pair();
    t_priority();
    t_passthru();
    t_cancel();
    t_disable();
    t_clamp();
    t_hold();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    wait (cyc > 20000);
    fails++;
    $display("FAIL watchdog: actual %0d expected below 20000 cycles", cyc);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule